// File: doc/BRIEF.md
# Register-Resident Page Translator with Reference Tracking

This block maps a 16-bit virtual address onto a 16-bit physical address using 4 KiB pages. The upper four address bits pick one of sixteen table slots held in flip-flops. Each slot stores a four-bit frame number and a reference bit. The low twelve bits pass straight through as the page offset. The physical address is the frame number of the selected slot placed above that offset.

The translation path is purely combinational. A lookup strobe marks an address as really used. On the next clock edge, the strobe sets the reference bit of the slot that served the lookup. A single clear pulse drops every reference bit at once. Software or a sweeper thread can use this to age pages.

A write port loads a frame number into one slot and resets that slot's reference bit. The lookup interface has no back-pressure: a lookup is accepted every cycle the strobe is high, so no ready signal exists.

Top module: `pxl_translator`

## Requirements
- R1: After reset, every slot holds frame 0 and every reference bit is 0.
- R2: `lk_paddr[15:12]` equals the frame stored in slot `lk_vaddr[15:12]`, combinationally and whether or not `lk_valid` is high.
- R3: `lk_paddr[11:0]` always equals `lk_vaddr[11:0]`.
- R4: When `lk_valid` is high at a clock edge, the reference bit of slot `lk_vaddr[15:12]` reads 1 after that edge. When `lk_valid` is low, no reference bit changes.
- R5: When `ref_clear` is high at a clock edge, every reference bit reads 0 after that edge.
- R6: When `ref_clear` and `lk_valid` are both high at an edge, the looked-up slot's reference bit becomes 1 and all other bits become 0.
- R7: When `wr_en` is high at an edge, slot `wr_page` takes `wr_frame` and its reference bit becomes 0. Other slots keep their frames.
- R8: When a write and a lookup hit the same slot at the same edge, the write wins and the reference bit ends at 0. The translation in that cycle uses the old frame.
- R9: Bit i of `ref_bits` is the reference bit of slot i, for i from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe; marks the slot as referenced |
| lk_vaddr | input | 16 | Virtual address to translate |
| lk_paddr | output | 16 | Translated physical address (combinational) |
| wr_en | input | 1 | Table write strobe |
| wr_page | input | 4 | Slot index to load |
| wr_frame | input | 4 | Frame number to store |
| ref_clear | input | 1 | Zero all reference bits |
| ref_bits | output | 16 | Reference bit of each slot |

## Verification
Three functions can fall in the same cycle: a lookup with a clear pulse, and a lookup with a table write to the same slot. The bench raises both strobes on one edge in each pairing. It then reads the whole `ref_bits` vector against a mask it predicts itself. For the write case, it also checks that the translation seen during that cycle still carries the old frame, and that the next one carries the new frame.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int unsigned PXL_VA_W  = 16;
  localparam int unsigned PXL_OFF_W = 12;
  localparam int unsigned PXL_FR_W  = 4;
endpackage

// File: rtl/pxl_dec.sv
module pxl_dec #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     onehot
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign onehot[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/pxl_entry.sv
module pxl_entry #(
  parameter int unsigned FR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            wsel,
  input  logic [FR_W-1:0] wframe,
  input  logic            clr,
  output logic [FR_W-1:0] frame,
  output logic            ref_bit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame   <= '0;
      ref_bit <= 1'b0;
    end else begin
      if (wsel) frame <= wframe;
      if (wsel)     ref_bit <= 1'b0;
      else if (hit) ref_bit <= 1'b1;
      else if (clr) ref_bit <= 1'b0;
    end
  end

  AST_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wsel |=> ref_bit); // R4
  AST_REF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit && !wsel |=> !ref_bit); // R5
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wsel |=> (frame == $past(wframe)) && !ref_bit); // R7
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel |=> $stable(frame)); // R7
  AST_REF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wsel && !hit && !clr |=> $stable(ref_bit)); // R4
endmodule

// File: rtl/pxl_translator.sv
module pxl_translator
  import pxl_pkg::*;
#(
  parameter int unsigned VA_W  = PXL_VA_W,
  parameter int unsigned OFF_W = PXL_OFF_W,
  parameter int unsigned FR_W  = PXL_FR_W,
  localparam int unsigned PG_W = VA_W - OFF_W,
  localparam int unsigned NENT = 1 << PG_W,
  localparam int unsigned PA_W = FR_W + OFF_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  output logic [PA_W-1:0] lk_paddr,
  input  logic            wr_en,
  input  logic [PG_W-1:0] wr_page,
  input  logic [FR_W-1:0] wr_frame,
  input  logic            ref_clear,
  output logic [NENT-1:0] ref_bits
);
  logic [PG_W-1:0]  vpage;
  logic [NENT-1:0]  hit_vec;
  logic [NENT-1:0]  wsel_vec;
  logic [FR_W-1:0]  frames [NENT];

  assign vpage = lk_vaddr[VA_W-1:OFF_W];

  pxl_dec #(.SEL_W(PG_W)) u_hit_dec (
    .en(lk_valid), .sel(vpage), .onehot(hit_vec));
  pxl_dec #(.SEL_W(PG_W)) u_wr_dec (
    .en(wr_en), .sel(wr_page), .onehot(wsel_vec));

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    pxl_entry #(.FR_W(FR_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .hit(hit_vec[i]), .wsel(wsel_vec[i]), .wframe(wr_frame),
      .clr(ref_clear), .frame(frames[i]), .ref_bit(ref_bits[i]));
  end

  assign lk_paddr = {frames[vpage], lk_vaddr[OFF_W-1:0]};

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec) && $onehot0(wsel_vec)); // R9
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clear && !lk_valid |=> ref_bits == '0); // R5
  AST_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clear && lk_valid && !(wr_en && wr_page == vpage) |=> $countones(ref_bits) == 1); // R6
endmodule

// File: tb/pxl_translator_test.sv
module pxl_translator_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_vaddr = '0;
  logic [15:0] lk_paddr;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_page = '0;
  logic [3:0]  wr_frame = '0;
  logic        ref_clear = 1'b0;
  logic [15:0] ref_bits;

  int checks = 0;
  int errors = 0;
  logic [3:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  pxl_translator uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_paddr(lk_paddr), .wr_en(wr_en), .wr_page(wr_page),
    .wr_frame(wr_frame), .ref_clear(ref_clear), .ref_bits(ref_bits));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] pg, input logic [3:0] fr);
    wr_en = 1'b1; wr_page = pg; wr_frame = fr;
    tick();
    wr_en = 1'b0;
    model[pg] = fr;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] mask;
    tick(); tick();
    // R1 reset state
    chk("R1 ref", ref_bits, 16'h0);
    for (int p = 0; p < 16; p++) begin
      lk_vaddr = {p[3:0], 12'h5A5}; #1;
      chk("R1 frame", lk_paddr, {4'h0, 12'h5A5});
    end
    rst_n = 1'b1;
    tick();
    // R7 load every slot; R2 fixed example mappings plus arithmetic fill
    for (int p = 0; p < 16; p++) wr(p[3:0], 4'((p * 7 + 3) & 15));
    wr(4'd14, 4'd3); wr(4'd3, 4'd10); wr(4'd10, 4'd5); wr(4'd7, 4'd15);
    chk("R7 writes leave ref clear", ref_bits, 16'h0);
    lk_vaddr = 16'hE12C; #1; chk("R2 ex1", lk_paddr, 16'h312C);
    lk_vaddr = 16'h3A9D; #1; chk("R2 ex2", lk_paddr, 16'hAA9D);
    lk_vaddr = 16'hACA1; #1; chk("R2 ex3", lk_paddr, 16'h5CA1);
    lk_vaddr = 16'h7001; #1; chk("R2 ex4", lk_paddr, 16'hF001);
    // R2/R3 sweep over pages and offsets
    for (int p = 0; p < 16; p++)
      for (int o = 0; o < 4096; o += 273) begin
        lk_vaddr = {p[3:0], o[11:0]}; #1;
        chk("R2 frame", {12'h0, lk_paddr[15:12]}, {12'h0, model[p]});
        chk("R3 offset", {4'h0, lk_paddr[11:0]}, {4'h0, o[11:0]});
      end
    // R4 addresses presented without strobe leave ref bits alone
    tick();
    chk("R4 no strobe", ref_bits, 16'h0);
    // R4/R9 lookups set individual bits
    mask = '0;
    for (int p = 1; p < 16; p += 3) begin
      lk_valid = 1'b1; lk_vaddr = {p[3:0], 12'h010};
      tick();
      lk_valid = 1'b0;
      mask[p] = 1'b1;
      chk("R4 R9 ref set", ref_bits, mask);
    end
    // R5 clear
    ref_clear = 1'b1; tick(); ref_clear = 1'b0;
    chk("R5 clear all", ref_bits, 16'h0);
    for (int p = 0; p < 16; p++) begin
      lk_valid = 1'b1; lk_vaddr = {p[3:0], 12'h000}; tick();
    end
    lk_valid = 1'b0;
    chk("R4 all set", ref_bits, 16'hFFFF);
    // R6 clear with simultaneous lookup
    ref_clear = 1'b1; lk_valid = 1'b1; lk_vaddr = 16'h9123;
    tick();
    ref_clear = 1'b0; lk_valid = 1'b0;
    chk("R6 clear+lookup", ref_bits, 16'h0200);
    // R7 rewrite of a referenced slot resets its bit
    lk_valid = 1'b1; lk_vaddr = 16'h4000; tick(); lk_valid = 1'b0;
    chk("R4 slot4", ref_bits, 16'h0210);
    wr(4'd4, 4'd12);
    chk("R7 ref reset", ref_bits, 16'h0200);
    lk_vaddr = 16'h4ABC; #1; chk("R7 new frame", lk_paddr, 16'hCABC);
    // R8 write and lookup same slot
    lk_valid = 1'b1; lk_vaddr = 16'h6777;
    wr_en = 1'b1; wr_page = 4'd6; wr_frame = 4'd1; #1;
    chk("R8 old frame", lk_paddr, {model[6], 12'h777});
    tick();
    wr_en = 1'b0; lk_valid = 1'b0; model[6] = 4'd1;
    chk("R8 write wins ref", ref_bits, 16'h0200);
    chk("R8 new frame", lk_paddr, 16'h1777);
    // R7 other slots untouched
    for (int p = 0; p < 16; p++) begin
      lk_vaddr = {p[3:0], 12'hFFF}; #1;
      chk("R7 others kept", lk_paddr, {model[p], 12'hFFF});
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule